// File: doc/BRIEF.md
# Column Offset Calibration Memory

This block sits behind a bank of column-parallel ADCs and removes each column's static offset from its 10-bit conversion results. Every column owns one signed entry in an offset memory. While the calibration input is high, each strobed sample is taken to be a conversion of a known reference level, such as an optical-black or zero-signal pixel. The residual error between the corrected sample and the reference code is added into that column's entry, and no result is produced.

While the calibration input is low, each strobed raw code has its column's stored offset subtracted. The difference is clamped to the legal code range and presented one cycle later with an output-valid flag. Each calibration step is bounded to the signed 7-bit range, and the stored value saturates at plus or minus 32 LSB. Because of these two limits, any offset inside the correctable range is reached within two calibrations of the same column.

A small state machine records what the last clock edge accepted. ST_IDLE means no sample was taken: the strobe was low or the column index was out of range. ST_CORR means a normal-mode sample was taken and a corrected code is being presented. ST_CAL means a calibration sample was taken and an offset entry was written. From any state, the next state is chosen by the current inputs alone. An in-range strobe with calibration low goes to ST_CORR. An in-range strobe with calibration high goes to ST_CAL. Anything else goes to ST_IDLE. Reset forces ST_IDLE.

Top module: `col_ofs_cal`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid is low and every column's offset entry is zero, so a normal-mode read returns the raw code unchanged.
- R2: A normal-mode sample (in_valid=1, cal_mode=0, col_idx < NUM_COLS) produces out_valid=1 in the next cycle only, with out_code = raw_code minus that column's stored offset.
- R3: The corrected code is clamped: a difference below 0 gives 0, and a difference above 1023 gives 1023.
- R4: A calibration sample (in_valid=1, cal_mode=1) produces no out_valid. It computes err = raw_code − offset − REF_CODE, limits err to −64..63, and adds it to the column's offset.
- R5: The stored offset never leaves −32..+32. A sum outside that range saturates at the nearer limit.
- R6: For a reference raw value whose target offset (raw_code − REF_CODE) lies in −32..+32, two consecutive calibrations of a column leave exactly that target stored, from any starting offset.
- R7: Calibrating one column leaves every other column's offset unchanged.
- R8: A strobe whose col_idx is NUM_COLS or larger is ignored in both modes: no out_valid, and no offset changes.
- R9: With in_valid low, out_valid is low in the next cycle and no offset changes.
- R10: Back-to-back calibration samples on the same column in consecutive cycles each act on the offset left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the state and every offset entry |
| in_valid | input | 1 | Strobe: a sample is present on col_idx and raw_code |
| cal_mode | input | 1 | 1 = calibration sample, 0 = normal readout |
| col_idx | input | COL_W | Column the sample belongs to |
| raw_code | input | CODE_W (10) | Raw ADC conversion result |
| out_valid | output | 1 | Corrected code is valid this cycle |
| out_code | output | CODE_W (10) | Offset-corrected, clamped code |

## Verification
The bench builds the block with NUM_COLS=6 and REF_CODE=40. The 3-bit column index then has two out-of-range values, 6 and 7, that can be driven to exercise R8. A reference of 40 lets a raw code of 0 drive an offset to the −32 limit, and a raw code of 72 drives it to the +32 limit. This makes the widest move in R6, a change of 64 LSB, reachable, and shows that it clips at 63 on the first step. Directed sequences cover both clamp edges of the corrected code, saturation and back-to-back updates. Seeded random traffic then checks every output against a bench model of all six columns.

// File: rtl/col_cal_pkg.sv
package col_cal_pkg;

    // ST_IDLE: nothing accepted at the last edge
    // ST_CORR: corrected code on the output
    // ST_CAL : an offset entry was updated
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CORR = 2'd1,
        ST_CAL  = 2'd2
    } cal_state_e;

endpackage

// File: rtl/col_ofs_store.sv
module col_ofs_store #(
    parameter int NUM_COLS = 64,
    parameter int COL_W    = 6,
    parameter int OFS_W    = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COL_W-1:0]        rd_idx,
    output logic signed [OFS_W-1:0] rd_ofs,
    input  logic                    wr_en,
    input  logic [COL_W-1:0]        wr_idx,
    input  logic signed [OFS_W-1:0] wr_ofs
);

    logic signed [OFS_W-1:0] entry_q [NUM_COLS];

    for (genvar g = 0; g < NUM_COLS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_idx == COL_W'(g))) begin
                entry_q[g] <= wr_ofs;
            end
        end
    end

    always_comb begin
        rd_ofs = '0;
        for (int i = 0; i < NUM_COLS; i++) begin
            if (rd_idx == COL_W'(i)) begin
                rd_ofs = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/col_ofs_update.sv
module col_ofs_update #(
    parameter int CODE_W   = 10,
    parameter int OFS_W    = 7,
    parameter int OFS_LIM  = 32,
    parameter int REF_CODE = 0
) (
    input  logic [CODE_W-1:0]       raw,
    input  logic signed [OFS_W-1:0] cur_ofs,
    output logic signed [OFS_W-1:0] new_ofs
);

    localparam int ERR_W    = CODE_W + 3;
    localparam int STEP_MAX = (2 ** (OFS_W - 1)) - 1;
    localparam int STEP_MIN = -(2 ** (OFS_W - 1));

    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] step;
    logic signed [ERR_W-1:0] sum;

    always_comb begin
        err = $signed({{(ERR_W-CODE_W){1'b0}}, raw}) - ERR_W'(cur_ofs) - ERR_W'(REF_CODE);

        if (err > ERR_W'(STEP_MAX)) begin
            step = ERR_W'(STEP_MAX);
        end else if (err < ERR_W'(STEP_MIN)) begin
            step = ERR_W'(STEP_MIN);
        end else begin
            step = err;
        end

        sum = ERR_W'(cur_ofs) + step;

        if (sum > ERR_W'(OFS_LIM)) begin
            new_ofs = OFS_W'(OFS_LIM);
        end else if (sum < ERR_W'(-OFS_LIM)) begin
            new_ofs = OFS_W'(-OFS_LIM);
        end else begin
            new_ofs = OFS_W'(sum);
        end
    end

endmodule

// File: rtl/col_code_fix.sv
module col_code_fix #(
    parameter int CODE_W = 10,
    parameter int OFS_W  = 7
) (
    input  logic [CODE_W-1:0]       raw,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [CODE_W-1:0]       fixed
);

    localparam int DIF_W    = CODE_W + 2;
    localparam int CODE_MAX = (2 ** CODE_W) - 1;

    logic signed [DIF_W-1:0] diff;

    always_comb begin
        diff = $signed({2'b00, raw}) - DIF_W'(ofs);
        if (diff < 0) begin
            fixed = '0;
        end else if (diff > DIF_W'(CODE_MAX)) begin
            fixed = CODE_W'(CODE_MAX);
        end else begin
            fixed = diff[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/col_ofs_cal.sv
module col_ofs_cal
    import col_cal_pkg::*;
#(
    parameter int NUM_COLS = 64,
    parameter int CODE_W   = 10,
    parameter int OFS_W    = 7,
    parameter int OFS_LIM  = 32,
    parameter int REF_CODE = 0,
    parameter int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              cal_mode,
    input  logic [COL_W-1:0]  col_idx,
    input  logic [CODE_W-1:0] raw_code,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);

    cal_state_e              state_q;
    cal_state_e              state_d;
    logic                    col_ok;
    logic signed [OFS_W-1:0] ofs_rd_val;
    logic signed [OFS_W-1:0] ofs_wr_val;
    logic                    ofs_wr_en;
    logic [CODE_W-1:0]       fixed_code;
    logic [CODE_W-1:0]       code_q;

    assign col_ok = (32'(col_idx) < NUM_COLS);

    col_ofs_store #(
        .NUM_COLS (NUM_COLS),
        .COL_W    (COL_W),
        .OFS_W    (OFS_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (col_idx),
        .rd_ofs (ofs_rd_val),
        .wr_en  (ofs_wr_en),
        .wr_idx (col_idx),
        .wr_ofs (ofs_wr_val)
    );

    col_ofs_update #(
        .CODE_W   (CODE_W),
        .OFS_W    (OFS_W),
        .OFS_LIM  (OFS_LIM),
        .REF_CODE (REF_CODE)
    ) u_update (
        .raw     (raw_code),
        .cur_ofs (ofs_rd_val),
        .new_ofs (ofs_wr_val)
    );

    col_code_fix #(
        .CODE_W (CODE_W),
        .OFS_W  (OFS_W)
    ) u_fix (
        .raw   (raw_code),
        .ofs   (ofs_rd_val),
        .fixed (fixed_code)
    );

    // Next state is chosen by the inputs alone.
    always_comb begin
        unique case ({in_valid && col_ok, cal_mode})
            2'b10:   state_d = ST_CORR;
            2'b11:   state_d = ST_CAL;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: capture the corrected code on a normal-mode accept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (state_d == ST_CORR) begin
            code_q <= fixed_code;
        end
    end

    assign ofs_wr_en = (state_d == ST_CAL);
    assign out_valid = (state_q == ST_CORR);
    assign out_code  = code_q;

endmodule

// File: rtl/col_ofs_cal_chk.sv
module col_ofs_cal_chk #(
    parameter int NUM_COLS = 64,
    parameter int COL_W    = 6,
    parameter int OFS_W    = 7,
    parameter int OFS_LIM  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    cal_mode,
    input logic [COL_W-1:0]        col_idx,
    input logic                    out_valid,
    input logic                    wr_en,
    input logic signed [OFS_W-1:0] wr_ofs
);

    // R1: out_valid is low on the first edge after reset release
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);

    // R2: an in-range normal sample gives out_valid in the next cycle
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cal_mode && (32'(col_idx) < NUM_COLS)) |=> out_valid);

    // R4: a calibration sample produces no output
    a_r4_cal_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cal_mode) |=> !out_valid);

    // R5: every value written into the memory lies within the limits
    a_r5_ofs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_ofs <= OFS_W'(OFS_LIM)) && (wr_ofs >= OFS_W'(-OFS_LIM))));

    // R8: an out-of-range column neither writes nor produces output
    a_r8_range_nowr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (32'(col_idx) >= NUM_COLS)) |-> !wr_en);

    a_r8_range_noout: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (32'(col_idx) >= NUM_COLS)) |=> !out_valid);

    // R9: no strobe means no write and no output
    a_r9_idle_nowr: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !wr_en);

    a_r9_idle_noout: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

bind col_ofs_cal col_ofs_cal_chk #(
    .NUM_COLS (NUM_COLS),
    .COL_W    (COL_W),
    .OFS_W    (OFS_W),
    .OFS_LIM  (OFS_LIM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cal_mode  (cal_mode),
    .col_idx   (col_idx),
    .out_valid (out_valid),
    .wr_en     (ofs_wr_en),
    .wr_ofs    (ofs_wr_val)
);

// File: tb/test_col_ofs_cal.sv
module test_col_ofs_cal;

    localparam int CLK_PERIOD = 10;
    localparam int NCOL       = 6;
    localparam int CW         = 3;
    localparam int REFC       = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          cal_mode = 1'b0;
    logic [CW-1:0] col_idx = '0;
    logic [9:0]    raw_code = '0;
    logic          out_valid;
    logic [9:0]    out_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int mdl [NCOL];

    always #(CLK_PERIOD/2) clk = ~clk;

    col_ofs_cal #(
        .NUM_COLS (NCOL),
        .REF_CODE (REFC)
    ) i_col_ofs_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cal_mode  (cal_mode),
        .col_idx   (col_idx),
        .raw_code  (raw_code),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    function automatic int fix_code(int raw, int ofs);
        int v = raw - ofs;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    function automatic int next_ofs(int ofs, int raw);
        int e = raw - ofs - REFC;
        int s;
        if (e > 63) e = 63;
        if (e < -64) e = -64;
        s = ofs + e;
        if (s > 32) s = 32;
        if (s < -32) s = -32;
        return s;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobed sample; the result is sampled one time unit after the edge.
    task automatic put(bit cal, int col, int raw, string req);
        bit exp_v;
        int exp_c;
        @(negedge clk);
        in_valid = 1'b1;
        cal_mode = cal;
        col_idx  = CW'(col);
        raw_code = 10'(raw);
        exp_v = !cal && (col < NCOL);
        exp_c = (col < NCOL) ? fix_code(raw, mdl[col]) : 0;
        if (cal && col < NCOL) mdl[col] = next_ofs(mdl[col], raw);
        @(posedge clk);
        #1;
        chk({req, " valid"}, int'(out_valid), int'(exp_v));
        if (exp_v) chk({req, " code"}, int'(out_code), exp_c);
    endtask

    task automatic quiet(string req);
        @(negedge clk);
        in_valid = 1'b0;
        raw_code = 10'd0;
        @(posedge clk);
        #1;
        chk(req, int'(out_valid), 0);
    endtask

    // Read every column in normal mode to expose the stored offsets.
    task automatic sweep(string req);
        for (int c = 0; c < NCOL; c++) put(1'b0, c, 500, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < NCOL; c++) mdl[c] = 0;

        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset out_valid", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after release", int'(out_valid), 0);
        for (int c = 0; c < NCOL; c++) put(1'b0, c, 100 + c, "R1 zero offset");

        // R4/R5: saturate column 0 high, column 1 low
        put(1'b1, 0, REFC + 50, "R4 cal high");
        put(1'b1, 1, 0, "R5 cal low");
        put(1'b0, 0, 500, "R5 ofs +32");
        put(1'b0, 1, 500, "R5 ofs -32");

        // R3: both clamp edges
        put(1'b0, 0, 10, "R3 clamp low");
        put(1'b0, 1, 1000, "R3 clamp high");
        put(1'b0, 0, 32, "R3 exact zero");

        // R6: from -32 to +32 in two steps; first step clipped to 63
        put(1'b1, 1, REFC + 32, "R6 step one");
        put(1'b0, 1, 500, "R6 after one");
        put(1'b1, 1, REFC + 32, "R6 step two");
        put(1'b0, 1, 500, "R6 converged");

        // R7: calibrate column 3, others unchanged
        put(1'b1, 3, REFC + 7, "R7 cal col3");
        sweep("R7 neighbours");

        // R8: out-of-range columns in both modes
        put(1'b1, 6, 0, "R8 cal col6");
        put(1'b0, 7, 300, "R8 read col7");
        put(1'b1, 7, 1023, "R8 cal col7");
        sweep("R8 no change");

        // R9: idle cycles
        quiet("R9 idle");
        quiet("R9 idle again");
        sweep("R9 no change");

        // R10: back-to-back calibrations on one column
        put(1'b1, 2, REFC - 20, "R10 first");
        put(1'b1, 2, REFC - 20, "R10 second");
        put(1'b1, 2, REFC + 5, "R10 third");
        put(1'b0, 2, 500, "R10 result");

        // R2: random mixed traffic against the model
        for (int k = 0; k < 400; k++) begin
            int col = int'($urandom % 8);
            bit cal = ($urandom % 3) == 0;
            int raw;
            if (cal) begin
                raw = REFC - 70 + int'($urandom % 141);
                if (raw < 0) raw = 0;
            end else begin
                case ($urandom % 4)
                    0:       raw = int'($urandom % 40);
                    1:       raw = 1023 - int'($urandom % 40);
                    default: raw = int'($urandom % 1024);
                endcase
            end
            if (($urandom % 10) == 0) quiet("R9 random idle");
            put(cal, col, raw, "R2 random");
        end
        sweep("R2 final sweep");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule